// File: doc/BRIEF.md
# Byte-Programmed 16-bit Interval Timer

This block is a down-counting interval timer run from the system clock. Software reaches it through a small byte-wide register bus. A 16-bit reload value is written in two steps: the upper byte goes into a holding buffer first, and the write of the lower byte commits both bytes at once. A control register chooses the operating mode, an optional divide-by-8 prescale, whether the timer is held or running, an output enable and an interrupt enable.

Each time the count passes zero, the counter reloads and an expiry flag is raised. The timer output line then behaves according to the mode:

- **Free-running:** a square wave.
- **One-pulse:** a single high pulse.
- **Chained:** a level that follows a control bit.

The expiry flag and the interrupt enable leave the block as plain signals, so that a shared status and interrupt register can merge them. The flag is cleared by a two-step handshake. First that shared register is read while the flag is up. Then either byte of the count is read.

Top module: `pit16`

## Requirements
- R1: After reset, the control register reads 0x01, both count bytes read 0xFF, the expiry flag is 0, the timer output is 0 and the interrupt enable is 0. The reload value is also 0xFFFF.
- R2: The control register is at address 0 and reads back as written. Its fields are:
  - bit 0: hold
  - bit 1: clock select (stored only)
  - bit 2: divide-by-8
  - bits 5:3: mode
  - bit 6: interrupt enable, driven on `tmr_irq_en`
  - bit 7: output enable
- R3: A write to address 2 changes only a high-byte buffer. A write to address 3 loads the reload value with {buffer, data}. When the mode field is 000, that address-3 write also does the following, and it launches the timer when hold is 0:
  - presets the counter from the new value;
  - clears the flag;
  - drives the output low.
- R4: Reads at address 2 and address 3 return the high and low bytes of the current count.
  - The count drops by one per prescaled tick. A tick is every clock, or every 8th clock when divide-by-8 is set.
  - The prescaler restarts at every launch.
  - With reload value N, the flag rises f×(N+1) clocks after the launching write, where f is 1 or 8.
  - At expiry the counter reloads from the reload value.
- R5: Mode 000 and mode 010 (free-running):
  - a launch drives the output low;
  - each expiry inverts the output.
- R6: Mode 100 (one-pulse):
  - a launch drives the output low;
  - the output rises one prescaled tick later;
  - each expiry drives it low, where it stays on later expiries.
- R7: Mode 110 (chained):
  - a launch leaves the output unchanged;
  - each expiry sets the output to the output-enable bit.
- R8: `tmr_out` shows the internal output only when the mode is 110 or the output-enable bit is 1. Otherwise it is 0.
- R9: A control write with hold set does the following:
  - stops the timer;
  - presets the counter from the reload value;
  - clears the flag;
  - drives the output low, unless the new mode is 110.

  A control write with hold clear launches the timer only if it is stopped. A running timer keeps its count and its flag.
- R10: A read of the count clears the flag only when the last pulse on `stat_rd` saw the flag set. Any count read consumes that permission. An expiry in the same cycle wins over the clear.
- R11: A mode field with bit 3 set is unsupported. Such a launch leaves the timer stopped, with its count unchanged, no flag and no output change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 control, 2 count high, 3 count low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| stat_rd | input | 1 | Pulse: the shared status register holding the flag was read |
| tmr_out | output | 1 | Gated timer output line |
| tmr_flag | output | 1 | Expiry flag |
| tmr_irq_en | output | 1 | Timer interrupt enable bit |

## Verification
The embedded properties watch on every cycle:

- the count falls by exactly one per tick and reloads from the reload value on expiry;
- a held timer never runs;
- the output only rises on a tick;
- the reload value moves only on low-byte writes;
- the flag changes only on a set event, a clear event or an armed count read.

Only the bench scenarios can show exact period lengths for each prescale, reload value and mode. The same holds for the one-pulse rise time, the output gating, the order of the flag-clearing handshake and the refusal of unsupported modes.

// File: rtl/pit16_pkg.sv
package pit16_pkg;

    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 2 * BYTE_W;
    localparam int PRE_W_DEF = 3;

    typedef enum logic [1:0] {
        AD_CTRL   = 2'd0,
        AD_NONE   = 2'd1,
        AD_CNT_HI = 2'd2,
        AD_CNT_LO = 2'd3
    } pit_addr_e;

    typedef enum logic [1:0] {
        MD_FREE,
        MD_PULSE,
        MD_CHAIN,
        MD_UNSUP
    } pit_mode_e;

    typedef struct packed {
        logic       out_en;
        logic       irq_en;
        logic [2:0] mode;
        logic       div8;
        logic       clk_sel;
        logic       hold;
    } pit_ctrl_t;

    localparam pit_ctrl_t CTRL_RST = '{out_en: 1'b0, irq_en: 1'b0, mode: 3'b000,
                                       div8: 1'b0, clk_sel: 1'b0, hold: 1'b1};

    function automatic pit_mode_e decode_mode(input logic [2:0] m);
        if (m[0]) return MD_UNSUP;
        case (m[2:1])
            2'b10:   return MD_PULSE;
            2'b11:   return MD_CHAIN;
            default: return MD_FREE;
        endcase
    endfunction

endpackage

// File: rtl/pit16_regs.sv
module pit16_regs
    import pit16_pkg::*;
#(
    parameter int CW = CNT_W,
    localparam int BW = CW / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic [BW-1:0] wdata,
    output pit_ctrl_t     ctrl_q,
    output logic [CW-1:0] reload_q,
    output logic [CW-1:0] reload_d
);

    logic [BW-1:0] hi_buf_q;

    assign reload_d = {hi_buf_q, wdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RST;
            hi_buf_q <= '0;
            reload_q <= '1;
        end else begin
            if (wr_ctrl) ctrl_q   <= pit_ctrl_t'(wdata);
            if (wr_hi)   hi_buf_q <= wdata;
            if (wr_lo)   reload_q <= reload_d;
        end
    end

    // R3
    reload_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_lo |=> $stable(reload_q));

endmodule

// File: rtl/pit16_core.sv
module pit16_core
    import pit16_pkg::*;
#(
    parameter int CW    = CNT_W,
    parameter int PRE_W = PRE_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  pit_ctrl_t     ctrl_q,
    input  pit_ctrl_t     new_ctrl,
    input  logic          wr_ctrl,
    input  logic          wr_lo,
    input  logic [CW-1:0] reload_q,
    input  logic [CW-1:0] reload_d,
    output logic [CW-1:0] cnt_q,
    output logic          out_q,
    output logic          set_flag,
    output logic          clr_flag
);

    logic [CW-1:0]    cnt_d;
    logic [PRE_W-1:0] pre_q, pre_d;
    logic             run_q, run_d;
    logic             pend_q, pend_d;
    logic             out_d;
    logic             tick;
    logic             hold_evt, launch_evt, load_evt;
    pit_mode_e        cur_mode, new_mode;

    assign cur_mode   = decode_mode(ctrl_q.mode);
    assign new_mode   = decode_mode(new_ctrl.mode);
    assign tick       = run_q && (!ctrl_q.div8 || (&pre_q));
    assign hold_evt   = wr_ctrl && new_ctrl.hold;
    assign launch_evt = wr_ctrl && !new_ctrl.hold && !run_q;
    assign load_evt   = wr_lo && (ctrl_q.mode == 3'b000);

    always_comb begin
        cnt_d    = cnt_q;
        out_d    = out_q;
        run_d    = run_q;
        pend_d   = pend_q;
        pre_d    = run_q ? pre_q + 1'b1 : pre_q;
        set_flag = 1'b0;
        clr_flag = 1'b0;
        if (hold_evt) begin
            run_d    = 1'b0;
            pend_d   = 1'b0;
            cnt_d    = reload_q;
            clr_flag = 1'b1;
            if (new_mode != MD_CHAIN) out_d = 1'b0;
        end else if (launch_evt) begin
            if (new_mode == MD_UNSUP) begin
                run_d = 1'b0;
            end else begin
                run_d    = 1'b1;
                pre_d    = '0;
                clr_flag = 1'b1;
                pend_d   = (new_mode == MD_PULSE);
                if (new_mode != MD_CHAIN) out_d = 1'b0;
            end
        end else if (load_evt) begin
            cnt_d    = reload_d;
            clr_flag = 1'b1;
            out_d    = 1'b0;
            pend_d   = 1'b0;
            if (!ctrl_q.hold) begin
                run_d = 1'b1;
                pre_d = '0;
            end
        end else if (tick) begin
            pend_d = 1'b0;
            if (pend_q) out_d = 1'b1;
            if (cnt_q == '0) begin
                if (cur_mode == MD_UNSUP) begin
                    run_d = 1'b0;
                    out_d = out_q;
                end else begin
                    cnt_d    = reload_q;
                    set_flag = 1'b1;
                    case (cur_mode)
                        MD_FREE:  out_d = ~out_q;
                        MD_PULSE: out_d = 1'b0;
                        default:  out_d = ctrl_q.out_en;
                    endcase
                end
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '1;
            out_q  <= 1'b0;
            run_q  <= 1'b0;
            pend_q <= 1'b0;
            pre_q  <= '0;
        end else begin
            cnt_q  <= cnt_d;
            out_q  <= out_d;
            run_q  <= run_d;
            pend_q <= pend_d;
            pre_q  <= pre_d;
        end
    end

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_ctrl && !wr_lo && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

    // R4
    reload_on_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_ctrl && !wr_lo && cnt_q == '0 && cur_mode != MD_UNSUP)
        |=> cnt_q == $past(reload_q));

    // R9
    hold_stops_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.hold |-> !run_q);

    // R6
    out_rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_q) |-> $past(tick));

endmodule

// File: rtl/pit16_flag.sv
module pit16_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic stat_rd,
    input  logic cnt_rd,
    output logic flag_q
);

    logic arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            if (set_i)                 flag_q <= 1'b1;
            else if (clr_i)            flag_q <= 1'b0;
            else if (cnt_rd && arm_q)  flag_q <= 1'b0;
            if (stat_rd)               arm_q  <= flag_q;
            else if (cnt_rd)           arm_q  <= 1'b0;
        end
    end

    // R10
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(set_i));

    // R10
    flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q) |-> $past(clr_i || (cnt_rd && arm_q)));

endmodule

// File: rtl/pit16.sv
module pit16
    import pit16_pkg::*;
#(
    parameter int PRE_W = PRE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              stat_rd,
    output logic              tmr_out,
    output logic              tmr_flag,
    output logic              tmr_irq_en
);

    pit_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] reload_q, reload_d, cnt_q;
    logic             wr_ctrl, wr_hi, wr_lo, cnt_rd;
    logic             out_q, set_flag, clr_flag;
    pit_addr_e        addr;

    assign addr    = pit_addr_e'(bus_addr);
    assign wr_ctrl = bus_wr && (addr == AD_CTRL);
    assign wr_hi   = bus_wr && (addr == AD_CNT_HI);
    assign wr_lo   = bus_wr && (addr == AD_CNT_LO);
    assign cnt_rd  = bus_rd && (addr == AD_CNT_HI || addr == AD_CNT_LO);

    pit16_regs #(.CW(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wr_ctrl),
        .wr_hi    (wr_hi),
        .wr_lo    (wr_lo),
        .wdata    (bus_wdata),
        .ctrl_q   (ctrl_q),
        .reload_q (reload_q),
        .reload_d (reload_d)
    );

    pit16_core #(.CW(CNT_W), .PRE_W(PRE_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .ctrl_q   (ctrl_q),
        .new_ctrl (pit_ctrl_t'(bus_wdata)),
        .wr_ctrl  (wr_ctrl),
        .wr_lo    (wr_lo),
        .reload_q (reload_q),
        .reload_d (reload_d),
        .cnt_q    (cnt_q),
        .out_q    (out_q),
        .set_flag (set_flag),
        .clr_flag (clr_flag)
    );

    pit16_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_flag),
        .clr_i   (clr_flag),
        .stat_rd (stat_rd),
        .cnt_rd  (cnt_rd),
        .flag_q  (tmr_flag)
    );

    always_comb begin
        case (addr)
            AD_CTRL:   bus_rdata = ctrl_q;
            AD_CNT_HI: bus_rdata = cnt_q[CNT_W-1:BYTE_W];
            AD_CNT_LO: bus_rdata = cnt_q[BYTE_W-1:0];
            default:   bus_rdata = '0;
        endcase
    end

    assign tmr_out    = out_q && (ctrl_q.out_en || decode_mode(ctrl_q.mode) == MD_CHAIN);
    assign tmr_irq_en = ctrl_q.irq_en;

endmodule

// File: tb/pit16_bench.sv
module pit16_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, stat_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    wire  [7:0] bus_rdata;
    wire        tmr_out, tmr_flag, tmr_irq_en;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    pit16 u_pit16 (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .stat_rd    (stat_rd),
        .tmr_out    (tmr_out),
        .tmr_flag   (tmr_flag),
        .tmr_irq_en (tmr_irq_en)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc >= 150000);
        if (!done) begin
            fails++;
            $display("FAIL R4 watchdog actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic stat();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic wait_flag(output int k);
        k = 0;
        while (!tmr_flag && k < 40000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic wait_out(input logic v, output int k);
        k = 0;
        while (tmr_out != v && k < 40000) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        int d, k, k2, f, p;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d); chk("R1 ctrl", d, 8'h01);
        rd(2'd2, d); chk("R1 cnt_hi", d, 8'hFF);
        rd(2'd3, d); chk("R1 cnt_lo", d, 8'hFF);
        chk("R1 flag", tmr_flag, 0);
        chk("R1 out", tmr_out, 0);
        chk("R1 irq_en", tmr_irq_en, 0);

        // R2 control readback and interrupt enable field
        wr(2'd0, 8'h41);
        chk("R2 irq_en", tmr_irq_en, 1);
        rd(2'd0, d); chk("R2 ctrl_rb", d, 8'h41);
        wr(2'd0, 8'h01);
        chk("R2 irq_en_off", tmr_irq_en, 0);

        // R3 high byte buffered until low byte
        wr(2'd2, 8'h12);
        rd(2'd2, d); chk("R3 hi_buffered", d, 8'hFF);
        wr(2'd3, 8'h34);
        rd(2'd2, d); chk("R3 hi_commit", d, 8'h12);
        rd(2'd3, d); chk("R3 lo_commit", d, 8'h34);

        // R4 R5 period sweep in free-running mode
        for (int dv = 0; dv < 2; dv++) begin
            for (int n = 0; n < 7; n++) begin
                f = dv ? 8 : 1;
                p = f * (n + 1);
                wr(2'd0, 8'h81 | (dv << 2));
                wr(2'd2, 8'h00);
                wr(2'd3, n[7:0]);
                chk("R5 out_low_preset", tmr_out, 0);
                wr(2'd0, 8'h80 | (dv << 2));
                wait_flag(k);
                chk($sformatf("R4 period n=%0d f=%0d", n, f), k, p);
                chk("R5 toggle_high", tmr_out, 1);
                wait_out(1'b0, k2);
                chk($sformatf("R5 second_half n=%0d f=%0d", n, f), k2, p);
            end
        end

        // R4 running count, R9 no relaunch while running
        wr(2'd0, 8'h81); wr(2'd2, 8'h00); wr(2'd3, 8'd100);
        wr(2'd0, 8'h80);
        repeat (10) @(negedge clk);
        rd(2'd3, d); chk("R4 running_count", d, 90);
        wr(2'd0, 8'h80);
        rd(2'd3, d); chk("R9 no_relaunch_count", d, 88);
        wr(2'd0, 8'h85); wr(2'd3, 8'd20);
        wr(2'd0, 8'h84);
        repeat (24) @(negedge clk);
        rd(2'd3, d); chk("R4 div8_count", d, 17);

        // R3 low-byte write in mode 000 restarts a running timer
        wait_flag(k);
        chk("R3 flag_before_restart", tmr_flag, 1);
        wr(2'd2, 8'h00); wr(2'd3, 8'd4);
        chk("R3 restart_flag_clear", tmr_flag, 0);
        chk("R3 restart_out_low", tmr_out, 0);
        wait_flag(k); chk("R3 restart_period", k, 40);

        // R8 output gating, R9 running control write keeps flag
        wr(2'd0, 8'h01); wr(2'd2, 8'h00); wr(2'd3, 8'd200);
        wr(2'd0, 8'h00);
        wait_flag(k); chk("R4 long_period", k, 201);
        chk("R8 gated_low", tmr_out, 0);
        wr(2'd0, 8'h80);
        chk("R8 enabled_high", tmr_out, 1);
        chk("R9 flag_kept", tmr_flag, 1);

        // R10 flag clearing handshake
        rd(2'd3, d); chk("R10 no_clear_without_stat", tmr_flag, 1);
        stat();
        rd(2'd2, d); chk("R10 clear_after_stat", tmr_flag, 0);
        stat();
        wait_flag(k);
        rd(2'd3, d); chk("R10 stale_stat_no_clear", tmr_flag, 1);
        stat();
        rd(2'd3, d); chk("R10 clear_second", tmr_flag, 0);

        // R6 one-pulse mode
        for (int dv = 0; dv < 2; dv++) begin
            for (int n = 1; n < 4; n += 2) begin
                f = dv ? 8 : 1;
                wr(2'd0, 8'h01 | (dv << 2)); wr(2'd2, 8'h00); wr(2'd3, n[7:0]);
                wr(2'd0, 8'hA1 | (dv << 2));
                wr(2'd0, 8'hA0 | (dv << 2));
                chk("R6 launch_low", tmr_out, 0);
                wait_out(1'b1, k);
                chk($sformatf("R6 rise n=%0d f=%0d", n, f), k, f);
                wait_flag(k2);
                chk($sformatf("R6 expiry n=%0d f=%0d", n, f), k + k2, f * (n + 1));
                chk("R6 low_at_expiry", tmr_out, 0);
                repeat (f * (n + 1) + 2) @(negedge clk);
                chk("R6 stays_low", tmr_out, 0);
            end
        end

        // R7 chained mode, R9 hold behaviour per mode
        wr(2'd0, 8'h01); wr(2'd2, 8'h00); wr(2'd3, 8'd2);
        wr(2'd0, 8'hB1);
        wr(2'd0, 8'hB0);
        chk("R7 launch_unchanged", tmr_out, 0);
        wait_flag(k); chk("R7 period", k, 3);
        chk("R7 out_follows_enable", tmr_out, 1);
        wr(2'd0, 8'hB1);
        chk("R9 chain_hold_keeps_out", tmr_out, 1);
        chk("R9 hold_clears_flag", tmr_flag, 0);
        rd(2'd3, d); chk("R9 hold_presets", d, 2);
        wr(2'd0, 8'h31);
        chk("R8 chain_visible", tmr_out, 1);
        wr(2'd0, 8'h81);
        chk("R9 hold_drives_low", tmr_out, 0);

        // R11 unsupported mode refuses to launch
        wr(2'd2, 8'h00); wr(2'd3, 8'd5);
        wr(2'd0, 8'h89);
        wr(2'd0, 8'h88);
        repeat (20) @(negedge clk);
        chk("R11 no_flag", tmr_flag, 0);
        rd(2'd3, d); chk("R11 count_frozen", d, 5);
        chk("R11 out_low", tmr_out, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule